// File: doc/BRIEF.md
# Nonvolatile memory command controller

This block holds the command register of a flash and EEPROM controller and sequences the operations that the register selects. Software writes a 7-bit command code over a small register bus. A command write takes effect only inside a short unlock window. The window is opened by writing a key byte to a separate protection register. The two whole-memory erase commands start as soon as they are accepted. Every other valid command only arms an operation, which starts on the next store access that the core makes to a memory address.

Each start is a one-cycle pulse, together with flags that describe the operation for the memory back end: which memory is targeted, whether it erases and/or writes, and the erase span as a power of two. The back end here is a busy timer. It stays busy for a fixed base number of cycles multiplied by the erase span. The controller also enforces the command discipline and reports a violation in a 2-bit status code. A direct switch between two active commands is refused. A reserved code is refused. An active command issued while the memory is busy is refused.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: After reset the command register reads 0x00, the status code is 0 (no error), busy is low and no start pulse is issued.
- R2: A write to the command register at offset 0 is accepted only if the key byte 0x9D was written to offset 4 within the last 4 cycles. The write must land on one of the 4 clock edges after the key write. One command write closes the window. A write outside the window changes neither the command nor the status.
- R3: Valid codes are 0x00, 0x01, 0x02, 0x08 to 0x0D, 0x12, 0x13, 0x18 to 0x1D, 0x20 and 0x30. Any other code is refused: the command register keeps its value and the status becomes 2 (illegal). Reads at offset 0 return the command and reads at offset 2 return the status in bits 1:0.
- R4: Changing the register from one active code (not 0x00 or 0x01) to a different active code is refused with status 2. Passing through 0x00 or 0x01 is allowed, and every accepted write clears the status to 0.
- R5: With an arming code held (0x02, 0x08 to 0x0D, 0x12, 0x13, 0x18 to 0x1D), a store access while not busy produces a start pulse one cycle later. A store access has no effect when the register holds 0x00, 0x01, 0x20 or 0x30, or while busy.
- R6: An accepted write of 0x20 or 0x30 produces a start pulse at the edge that accepts it.
- R7: 0x20 is refused with status 2 unless the debug-access input is high. When accepted, it targets flash, and it targets the EEPROM only while the EEPROM-save fuse input is low. 0x30 targets the EEPROM only.
- R8: While busy, a write of any code other than 0x00 or 0x01 leaves the register unchanged and sets status 1 (collision). 0x00 and 0x01 are still accepted.
- R9: Busy rises with the start pulse and stays high for BASE_CYCLES shifted left by the span exponent. The exponent is bits 2:0 of the code for 0x08 to 0x0D and 0x18 to 0x1D, and 0 for all other codes.
- R10: The operation flags follow the code. Flash is targeted by 0x02, 0x08 to 0x0D and 0x20. The EEPROM is targeted by 0x12, 0x13, 0x18 to 0x1D and 0x30. Erase is set for 0x08 to 0x0D, 0x13, 0x18 to 0x1D, 0x20 and 0x30. Write is set for 0x02, 0x12 and 0x13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset (0 command, 2 status, 4 key) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| mem_store | input | 1 | Store access to a memory address |
| dbg_access | input | 1 | Access comes from the debug interface |
| eesave_fuse | input | 1 | Preserve EEPROM on whole-chip erase |
| busy | output | 1 | Memory back end busy |
| op_start | output | 1 | One-cycle operation start pulse |
| op_flash | output | 1 | Operation targets flash |
| op_eeprom | output | 1 | Operation targets EEPROM |
| op_erase | output | 1 | Operation erases |
| op_write | output | 1 | Operation writes |
| op_span_log | output | 3 | Erase span exponent (span = 2^n units) |
| cmd_value | output | 7 | Current command register |
| err_code | output | 2 | Status: 0 none, 1 collision, 2 illegal |

## Verification
A wrong command register shows at the ports in two ways. It appears on cmd_value in the cycle after the write. It also appears later, as a start pulse that is missing, unwanted or carries the wrong flags on the next store. Errors in the unlock count appear as a write accepted or refused at exactly the fifth edge after the key. Errors in the busy timer appear as a busy length that differs from BASE_CYCLES times the span. They also appear as a collision that is not reported while the timer runs. The bench counts busy cycles exactly and probes the window at its last open edge and its first closed edge, so off-by-one faults are caught.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;

    typedef logic [6:0] cmd_t;

    localparam cmd_t C_NOCMD  = 7'h00;
    localparam cmd_t C_NOOP   = 7'h01;
    localparam cmd_t C_FL_WR  = 7'h02;
    localparam cmd_t C_EE_WR  = 7'h12;
    localparam cmd_t C_EE_EWR = 7'h13;
    localparam cmd_t C_ALL_ER = 7'h20;
    localparam cmd_t C_EE_ALL = 7'h30;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_COLLIDE = 2'd1,
        ERR_ILLEGAL = 2'd2
    } err_e;

    typedef struct packed {
        logic       flash;
        logic       eeprom;
        logic       erase;
        logic       write;
        logic [2:0] span_log;
    } op_t;

    function automatic logic fl_range(cmd_t c);
        return (c >= 7'h08) && (c <= 7'h0D);
    endfunction

    function automatic logic ee_range(cmd_t c);
        return (c >= 7'h18) && (c <= 7'h1D);
    endfunction

    function automatic logic is_idle(cmd_t c);
        return (c == C_NOCMD) || (c == C_NOOP);
    endfunction

    function automatic logic is_immediate(cmd_t c);
        return (c == C_ALL_ER) || (c == C_EE_ALL);
    endfunction

    function automatic logic is_arming(cmd_t c);
        return (c == C_FL_WR) || (c == C_EE_WR) || (c == C_EE_EWR) ||
               fl_range(c) || ee_range(c);
    endfunction

    function automatic logic is_valid(cmd_t c);
        return is_idle(c) || is_immediate(c) || is_arming(c);
    endfunction

    function automatic op_t decode(cmd_t c, logic keep_ee);
        op_t o;
        o.flash    = (c == C_FL_WR) || fl_range(c) || (c == C_ALL_ER);
        o.eeprom   = (c == C_EE_WR) || (c == C_EE_EWR) || ee_range(c) ||
                     (c == C_EE_ALL) || ((c == C_ALL_ER) && !keep_ee);
        o.erase    = fl_range(c) || ee_range(c) || (c == C_EE_EWR) ||
                     is_immediate(c);
        o.write    = (c == C_FL_WR) || (c == C_EE_WR) || (c == C_EE_EWR);
        o.span_log = (fl_range(c) || ee_range(c)) ? c[2:0] : 3'd0;
        return o;
    endfunction

endpackage

// File: rtl/nvm_ccp_gate.sv
module nvm_ccp_gate #(
    parameter logic [7:0] KEY = 8'h9D,
    parameter int         WIN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    input  logic       consume,
    output logic       open
);
    localparam int CW = $clog2(WIN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } gate_s;

    gate_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (key_wr && key_data == KEY)
            s_d.cnt = CW'(WIN);
        else if (consume)
            s_d.cnt = '0;
        else if (s_q.cnt != '0)
            s_d.cnt = s_q.cnt - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign open = (s_q.cnt != '0);

    // R2: a protected write shuts the window
    a_r2_single_use: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && open && !key_wr) |=> !open);
endmodule

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer #(
    parameter int BASE_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] span_log,
    output logic       busy
);
    localparam int CNT_W = $clog2(BASE_CYCLES * 128 + 1);
    localparam logic [CNT_W-1:0] BASE_V = CNT_W'(BASE_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    tmr_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start)
            s_d.cnt = BASE_V << span_log;
        else if (s_q.cnt != '0)
            s_d.cnt = s_q.cnt - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = (s_q.cnt != '0);

    // R9: a start makes the back end busy on the next cycle
    a_r9_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R5: the sequencer never restarts a running operation
    a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl
    import nvm_cmd_pkg::*;
#(
    parameter int         ADDR_W        = 3,
    parameter logic [7:0] UNLOCK_KEY    = 8'h9D,
    parameter int         UNLOCK_CYCLES = 4,
    parameter int         BASE_CYCLES   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              mem_store,
    input  logic              dbg_access,
    input  logic              eesave_fuse,
    output logic              busy,
    output logic              op_start,
    output logic              op_flash,
    output logic              op_eeprom,
    output logic              op_erase,
    output logic              op_write,
    output logic [2:0]        op_span_log,
    output logic [6:0]        cmd_value,
    output logic [1:0]        err_code
);
    localparam logic [ADDR_W-1:0] OFF_CMD  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] OFF_KEY  = ADDR_W'(4);

    typedef struct packed {
        cmd_t cmd;
        err_e err;
        logic start;
        op_t  op;
    } ctl_s;

    ctl_s s_d, s_q;

    logic cmd_wr, key_wr, unlocked, start_c;
    cmd_t new_cmd;
    op_t  op_c;

    assign cmd_wr  = reg_we && (reg_addr == OFF_CMD);
    assign key_wr  = reg_we && (reg_addr == OFF_KEY);
    assign new_cmd = reg_wdata[6:0];

    nvm_ccp_gate #(
        .KEY (UNLOCK_KEY),
        .WIN (UNLOCK_CYCLES)
    ) i_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_data (reg_wdata),
        .consume  (cmd_wr),
        .open     (unlocked)
    );

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        start_c   = 1'b0;
        op_c      = s_q.op;
        if (cmd_wr && unlocked) begin
            if (busy && !is_idle(new_cmd))
                s_d.err = ERR_COLLIDE;
            else if (!is_valid(new_cmd))
                s_d.err = ERR_ILLEGAL;
            else if (!is_idle(s_q.cmd) && !is_idle(new_cmd) && new_cmd != s_q.cmd)
                s_d.err = ERR_ILLEGAL;
            else if (new_cmd == C_ALL_ER && !dbg_access)
                s_d.err = ERR_ILLEGAL;
            else begin
                s_d.cmd = new_cmd;
                s_d.err = ERR_NONE;
                if (is_immediate(new_cmd)) begin
                    start_c = 1'b1;
                    op_c    = decode(new_cmd, eesave_fuse);
                end
            end
        end else if (mem_store && !busy && is_arming(s_q.cmd)) begin
            start_c = 1'b1;
            op_c    = decode(s_q.cmd, eesave_fuse);
        end
        s_d.start = start_c;
        s_d.op    = op_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.err <= ERR_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    nvm_busy_timer #(
        .BASE_CYCLES (BASE_CYCLES)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_c),
        .span_log (op_c.span_log),
        .busy     (busy)
    );

    always_comb begin
        case (reg_addr)
            OFF_CMD:  reg_rdata = {1'b0, s_q.cmd};
            OFF_STAT: reg_rdata = {6'd0, s_q.err};
            default:  reg_rdata = 8'd0;
        endcase
    end

    assign op_start    = s_q.start;
    assign op_flash    = s_q.op.flash;
    assign op_eeprom   = s_q.op.eeprom;
    assign op_erase    = s_q.op.erase;
    assign op_write    = s_q.op.write;
    assign op_span_log = s_q.op.span_log;
    assign cmd_value   = s_q.cmd;
    assign err_code    = s_q.err;

    // R2: locked writes leave command and status alone
    a_r2_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !unlocked) |=> (cmd_value == $past(cmd_value)) && (err_code == $past(err_code)));
    // R3: the register only ever holds a defined code
    a_r3_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
        is_valid(cmd_value));
    // R4: every change passes through an idle code
    a_r4_via_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_value) |-> (is_idle($past(cmd_value)) || is_idle(cmd_value)));
    // R5: start is a single-cycle pulse that coincides with busy
    a_r5_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> busy ##1 !op_start);
    // R8: active code while busy is a collision
    a_r8_collision: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && unlocked && busy && !is_idle(new_cmd)) |=>
        (err_code == ERR_COLLIDE) && (cmd_value == $past(cmd_value)));
endmodule

// File: tb/test_nvm_cmd_ctrl.sv
module test_nvm_cmd_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       mem_store = 1'b0;
    logic       dbg_access = 1'b0;
    logic       eesave_fuse = 1'b0;
    logic       busy, op_start, op_flash, op_eeprom, op_erase, op_write;
    logic [2:0] op_span_log;
    logic [6:0] cmd_value;
    logic [1:0] err_code;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    nvm_cmd_ctrl i_nvm_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_store(mem_store),
        .dbg_access(dbg_access), .eesave_fuse(eesave_fuse), .busy(busy),
        .op_start(op_start), .op_flash(op_flash), .op_eeprom(op_eeprom),
        .op_erase(op_erase), .op_write(op_write), .op_span_log(op_span_log),
        .cmd_value(cmd_value), .err_code(err_code)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(logic [2:0] a, logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 3'd0;
    endtask

    task automatic unlock();
        bus_wr(3'd4, 8'h9D);
    endtask

    task automatic cmd_w(logic [7:0] v);
        unlock();
        bus_wr(3'd0, v);
    endtask

    task automatic store();
        mem_store = 1'b1;
        @(negedge clk);
        mem_store = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        int n;
        busy_len(n);
    endtask

    task automatic t_reset();
        check("R1", "cmd", cmd_value, 0);
        check("R1", "err", err_code, 0);
        check("R1", "busy", busy, 0);
        check("R1", "start", op_start, 0);
    endtask

    task automatic t_protect();
        bus_wr(3'd0, 8'h02);
        check("R2", "locked cmd", cmd_value, 0);
        check("R2", "locked err", err_code, 0);
        unlock();
        repeat (4) @(negedge clk);
        bus_wr(3'd0, 8'h02);
        check("R2", "expired cmd", cmd_value, 0);
        unlock();
        repeat (3) @(negedge clk);
        bus_wr(3'd0, 8'h01);
        check("R2", "last open edge", cmd_value, 1);
        bus_wr(3'd0, 8'h00);
        check("R2", "window consumed", cmd_value, 1);
        cmd_w(8'h00);
    endtask

    task automatic t_flash_write();
        int n;
        cmd_w(8'h02);
        check("R5", "armed cmd", cmd_value, 2);
        check("R5", "no start on arm", op_start, 0);
        check("R5", "idle after arm", busy, 0);
        store();
        check("R5", "start on store", op_start, 1);
        check("R10", "flash", op_flash, 1);
        check("R10", "eeprom", op_eeprom, 0);
        check("R10", "write", op_write, 1);
        check("R10", "erase", op_erase, 0);
        busy_len(n);
        check("R9", "busy len write", n, 4);
    endtask

    task automatic t_direct_change();
        cmd_w(8'h08);
        check("R4", "direct change err", err_code, 2);
        check("R4", "direct change cmd", cmd_value, 2);
        cmd_w(8'h00);
        check("R4", "err cleared", err_code, 0);
        cmd_w(8'h08);
        check("R4", "via idle cmd", cmd_value, 8);
    endtask

    task automatic t_span();
        int n;
        cmd_w(8'h00);
        cmd_w(8'h0B);
        store();
        check("R9", "span log", op_span_log, 3);
        check("R10", "erase", op_erase, 1);
        check("R10", "flash", op_flash, 1);
        busy_len(n);
        check("R9", "busy len 8 pages", n, 32);
    endtask

    task automatic t_collision();
        cmd_w(8'h00);
        cmd_w(8'h0D);
        store();
        check("R8", "busy", busy, 1);
        cmd_w(8'h01);
        check("R8", "noop while busy", cmd_value, 1);
        check("R8", "noop no err", err_code, 0);
        cmd_w(8'h12);
        check("R8", "collide err", err_code, 1);
        check("R8", "collide cmd", cmd_value, 1);
        wait_idle();
        cmd_w(8'h12);
        store();
        check("R5", "ee start", op_start, 1);
        store();
        check("R5", "store while busy", op_start, 0);
        wait_idle();
    endtask

    task automatic t_reserved();
        cmd_w(8'h00);
        cmd_w(8'h05);
        check("R3", "reserved err", err_code, 2);
        check("R3", "reserved cmd", cmd_value, 0);
        reg_addr = 3'd2; #1;
        check("R3", "status read", reg_rdata, 2);
        reg_addr = 3'd0;
        cmd_w(8'h7F);
        check("R3", "reserved 7F cmd", cmd_value, 0);
        cmd_w(8'h1C);
        reg_addr = 3'd0; #1;
        check("R3", "cmd read", reg_rdata, 8'h1C);
        cmd_w(8'h00);
    endtask

    task automatic t_chip_erase();
        int n;
        dbg_access = 1'b0;
        cmd_w(8'h20);
        check("R7", "no debug err", err_code, 2);
        check("R7", "no debug cmd", cmd_value, 0);
        check("R7", "no debug start", op_start, 0);
        dbg_access = 1'b1; eesave_fuse = 1'b0;
        cmd_w(8'h20);
        check("R6", "immediate start", op_start, 1);
        check("R7", "cmd", cmd_value, 8'h20);
        check("R7", "flash", op_flash, 1);
        check("R7", "eeprom", op_eeprom, 1);
        busy_len(n);
        check("R9", "busy len chip", n, 4);
        store();
        check("R5", "store on immediate cmd", op_start, 0);
        cmd_w(8'h00);
        eesave_fuse = 1'b1;
        cmd_w(8'h20);
        check("R7", "eesave eeprom", op_eeprom, 0);
        check("R7", "eesave flash", op_flash, 1);
        wait_idle();
        dbg_access = 1'b0; eesave_fuse = 1'b0;
    endtask

    task automatic t_ee_erase();
        int n;
        cmd_w(8'h00);
        cmd_w(8'h30);
        check("R6", "ee all start", op_start, 1);
        check("R7", "ee all flash", op_flash, 0);
        check("R7", "ee all eeprom", op_eeprom, 1);
        wait_idle();
        cmd_w(8'h00);
        cmd_w(8'h1A);
        store();
        check("R10", "ee byte eeprom", op_eeprom, 1);
        check("R9", "ee span", op_span_log, 2);
        busy_len(n);
        check("R9", "busy len 4 bytes", n, 16);
    endtask

    task automatic t_idle_store();
        cmd_w(8'h00);
        store();
        check("R5", "store at nocmd", op_start, 0);
        check("R5", "busy at nocmd", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_protect();
        t_flash_write();
        t_direct_change();
        t_span();
        t_collision();
        t_reserved();
        t_chip_erase();
        t_ee_erase();
        t_idle_store();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule